// File: doc/BRIEF.md
# I2C Register-Write Slave

This block is a write-only slave on a two-wire I2C bus that turns bus transfers into writes on a small control register bank. It samples SCL and SDA with its own system clock, finds START and STOP conditions, checks the device address byte, and acknowledges by enabling an open-drain pull-down on SDA. Each written byte reaches the register bank as a one-cycle strobe with a register index and a data byte.

After the address byte, the master sends a subaddress byte. Bit 3 of that byte picks the transfer kind: 0 means one register write, and 1 means a burst in which the index advances after every data byte. Bits 2:0 give the first register index, and bits 7:4 are ignored. The system clock must run at least 20 times faster than SCL.

Top module: `i2c_regwr_slave`

## Requirements
- R1: After reset, sda_oe and wr_en are both 0.
- R2: An address byte of 0x80 (7-bit address 1000000 followed by write bit 0) is acknowledged: SDA reads low during the ninth SCL pulse.
- R3: An address byte other than 0x80, including the read form 0x81, is not acknowledged. No byte after it is acknowledged or written until the next START, even a byte equal to 0x80.
- R4: With subaddress bit 3 = 0, the first data byte is written once to the index in subaddress bits 2:0. Subaddress bits 7:4 have no effect.
- R5: In a single-write transfer, data bytes after the first are acknowledged and produce no write.
- R6: With subaddress bit 3 = 1, data byte k is written to index (bits 2:0 + k) mod 8, so the index wraps from 7 to 0, until STOP.
- R7: A repeated START restarts address decoding, whatever state the previous transfer left.
- R8: wr_en is high for exactly one system clock per write. wr_idx and wr_data change only in a cycle where wr_en is high.
- R9: The acknowledge pull-down is switched on and off only while SCL is low, and it is released after the ninth SCL pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 20x the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line as seen at the pad |
| sda_i | input | 1 | SDA line as seen at the pad |
| sda_oe | output | 1 | 1 = pull SDA low (acknowledge) |
| wr_en | output | 1 | Register write strobe, one clock wide |
| wr_idx | output | 3 | Register index of the write |
| wr_data | output | 8 | Data byte of the write |

## Verification
The assertions assume a well-behaved master. SDA changes only while SCL is low, except at START and STOP. SCL stays low for much longer than the synchronizer latency. The master releases SDA during every acknowledge pulse. The bench master keeps to these rules: it uses a quarter-bit period of eight system clocks and changes SDA only in the middle of the SCL low phase. The stimulus mixes good and corrupted address bytes, single and burst subaddresses, and random byte counts, so the acknowledge, discard and wrap paths are all exercised.

// File: rtl/i2cw_pkg.sv
// Shared types for the I2C register-write slave.
package i2cw_pkg;
    // Transfer phase of the byte engine.
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ADDR = 3'd1,
        PH_SUB  = 3'd2,
        PH_DATA = 3'd3,
        PH_SKIP = 3'd4
    } phase_t;
endpackage

// File: rtl/i2cw_sync.sv
// Multi-flop synchronizer for one asynchronous bus line.
// Assumes: the line idles high, so every stage resets to 1.
module i2cw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sr;

    // Shift the raw line through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sr <= '1;
        else        sr <= {sr[STAGES-2:0], din};
    end

    assign dout = sr[STAGES-1];
endmodule

// File: rtl/i2cw_bus_events.sv
// Finds SCL edges and START/STOP conditions in the synchronized lines.
// Assumes: inputs have already been synchronized to clk.
module i2cw_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    // Hold the previous sample of each line for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cw_engine.sv
// Byte engine: shifts in bytes, decodes the address and subaddress,
// drives the acknowledge and issues register write strobes.
// Assumes: one scl_rise or scl_fall per cycle at most; START and STOP win
// over bit activity in the same cycle.
module i2cw_engine
    import i2cw_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h40,
    parameter int         IDX_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic             sda_s,
    output logic             sda_oe,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data
);
    localparam int BYTE_W  = 8;
    localparam int CNT_W   = $clog2(BYTE_W + 1);
    localparam int INC_BIT = IDX_W;
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    phase_t             phase;
    logic [BYTE_W-1:0]  shreg;
    logic [CNT_W-1:0]   bitcnt;
    logic               in_ack;
    logic               burst;
    logic               first;
    logic [IDX_W-1:0]   idx;
    logic               byte_done;
    logic               ack_end;

    assign byte_done = scl_fall & (bitcnt == FULL) & ~in_ack;
    assign ack_end   = scl_fall & in_ack;

    // Transfer state machine, bit shifter and write strobe generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            shreg   <= '0;
            bitcnt  <= '0;
            in_ack  <= 1'b0;
            sda_oe  <= 1'b0;
            burst   <= 1'b0;
            first   <= 1'b0;
            idx     <= '0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                phase  <= PH_ADDR;
                bitcnt <= '0;
                in_ack <= 1'b0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                phase  <= PH_IDLE;
                bitcnt <= '0;
                in_ack <= 1'b0;
                sda_oe <= 1'b0;
            end else begin
                if (scl_rise && bitcnt < FULL) begin
                    shreg  <= {shreg[BYTE_W-2:0], sda_s};
                    bitcnt <= bitcnt + 1'b1;
                end
                if (ack_end) begin
                    sda_oe <= 1'b0;
                    in_ack <= 1'b0;
                    bitcnt <= '0;
                end else if (byte_done) begin
                    case (phase)
                        PH_ADDR: begin
                            if (shreg == {DEV_ADDR, 1'b0}) begin
                                sda_oe <= 1'b1;
                                in_ack <= 1'b1;
                                phase  <= PH_SUB;
                            end else begin
                                phase <= PH_SKIP;
                            end
                        end
                        PH_SUB: begin
                            sda_oe <= 1'b1;
                            in_ack <= 1'b1;
                            burst  <= shreg[INC_BIT];
                            idx    <= shreg[IDX_W-1:0];
                            first  <= 1'b1;
                            phase  <= PH_DATA;
                        end
                        PH_DATA: begin
                            sda_oe <= 1'b1;
                            in_ack <= 1'b1;
                            first  <= 1'b0;
                            if (first || burst) begin
                                wr_en   <= 1'b1;
                                wr_idx  <= idx;
                                wr_data <= shreg;
                                if (burst) idx <= idx + 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/i2c_regwr_slave.sv
// Top level: synchronizes SCL/SDA, finds bus events and runs the byte
// engine that writes the control register bank.
// Assumes: clk runs at least 20x the SCL rate; SDA is open drain outside.
module i2c_regwr_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'h40,
    parameter int         IDX_W       = 3,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines;
    logic [NLINES-1:0] sync_lines;
    logic scl_rise, scl_fall, start_det, stop_det;

    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_sync
        i2cw_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_lines[g]),
            .dout (sync_lines[g])
        );
    end

    i2cw_bus_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (sync_lines[1]),
        .sda_s    (sync_lines[0]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    i2cw_engine #(.DEV_ADDR(DEV_ADDR), .IDX_W(IDX_W)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det),
        .sda_s    (sync_lines[0]),
        .sda_oe   (sda_oe),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data)
    );
endmodule

// File: rtl/i2cw_checker.sv
// Protocol checker for the I2C register-write slave, bound to its top.
// Assumes: the master changes SDA only while SCL is low, except at START/STOP.
module i2cw_checker #(
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_i,
    input logic             sda_oe,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic [7:0]       wr_data
);
    // R8
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R8
    write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (wr_en || ($stable(wr_data) && $stable(wr_idx))));

    // R9
    ack_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);

    // R9
    ack_off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> !scl_i);

    // R4
    write_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> sda_oe);
endmodule

bind i2c_regwr_slave i2cw_checker #(.IDX_W(IDX_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl_i),
    .sda_oe (sda_oe),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_data(wr_data)
);

// File: tb/test_i2c_regwr_slave.sv
module test_i2c_regwr_slave;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic       sda_oe, wr_en;
    logic [2:0] wr_idx;
    logic [7:0] wr_data;
    wire        sda_line = sda_m & ~sda_oe;

    int checks = 0;
    int errors = 0;
    logic [2:0] cap_idx [64];
    logic [7:0] cap_dat [64];
    int   cap_n = 0;
    int   strobe_err = 0;
    logic prev_en = 1'b0;
    logic [7:0] tx_dat [8];

    always #5 clk = ~clk;

    i2c_regwr_slave i_i2c_regwr_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    // Capture every write strobe and catch strobes wider than one clock (R8).
    always @(negedge clk) begin
        if (wr_en && cap_n < 64) begin
            cap_idx[cap_n] = wr_idx;
            cap_dat[cap_n] = wr_data;
            cap_n = cap_n + 1;
        end
        if (wr_en && prev_en) strobe_err = strobe_err + 1;
        prev_en = wr_en;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic qwait;
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; qwait;
        scl_m = 1'b1; qwait;
        sda_m = 1'b0; qwait;
        scl_m = 1'b0; qwait;
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; qwait;
        scl_m = 1'b1; qwait;
        sda_m = 1'b1; qwait;
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; qwait;
            scl_m = 1'b1; qwait; qwait;
            scl_m = 1'b0; qwait;
        end
        sda_m = 1'b1; qwait;
        scl_m = 1'b1; qwait;
        acked = !sda_line;
        qwait;
        scl_m = 1'b0; qwait;
        chk(sda_oe == 1'b0, "R9", "ack released after ninth clock", int'(sda_oe), 0);
    endtask

    // One transfer: address, subaddress, n data bytes from tx_dat, STOP.
    task automatic run_txn(input logic [7:0] addr_b, input logic [7:0] sub, input int n);
        bit a;
        bit ok;
        int base, exp_n;
        logic [2:0] e_idx;
        base = cap_n;
        ok = (addr_b == 8'h80);
        bus_start;
        send_byte(addr_b, a);
        chk(a == ok, ok ? "R2" : "R3", "address ack", int'(a), int'(ok));
        send_byte(sub, a);
        chk(a == ok, ok ? "R2" : "R3", "subaddress ack", int'(a), int'(ok));
        for (int k = 0; k < n; k++) begin
            send_byte(tx_dat[k], a);
            chk(a == ok, (ok && k > 0 && !sub[3]) ? "R5" : (ok ? "R4" : "R3"),
                "data ack", int'(a), int'(ok));
        end
        bus_stop;
        repeat (4) @(negedge clk);
        exp_n = !ok ? 0 : (n == 0 ? 0 : (sub[3] ? n : 1));
        chk(cap_n - base == exp_n, !ok ? "R3" : (sub[3] ? "R6" : "R5"),
            "write count", cap_n - base, exp_n);
        if (cap_n - base == exp_n) begin
            for (int k = 0; k < exp_n; k++) begin
                e_idx = sub[3] ? 3'(sub[2:0] + 3'(k)) : sub[2:0];
                chk(cap_idx[base+k] == e_idx, sub[3] ? "R6" : "R4", "write index",
                    int'(cap_idx[base+k]), int'(e_idx));
                chk(cap_dat[base+k] == tx_dat[k], sub[3] ? "R6" : "R4", "write data",
                    int'(cap_dat[base+k]), int'(tx_dat[k]));
            end
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit a;
        int base;
        int unused;
        unused = $urandom(32'h5eed_1234);
        repeat (5) @(negedge clk);
        chk(sda_oe == 1'b0 && wr_en == 1'b0, "R1", "outputs in reset",
            int'({sda_oe, wr_en}), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(sda_oe == 1'b0 && wr_en == 1'b0, "R1", "outputs after reset",
            int'({sda_oe, wr_en}), 0);

        // R4: single write, upper subaddress bits set and must be ignored
        tx_dat[0] = 8'h3C;
        run_txn(8'h80, 8'hF2, 1);

        // R5: single write with two extra bytes, acked and discarded
        tx_dat[0] = 8'h11; tx_dat[1] = 8'h22; tx_dat[2] = 8'h33;
        run_txn(8'h80, 8'h07, 3);

        // R6: burst from index 6 wraps 7 -> 0 -> 1
        tx_dat[0] = 8'hA0; tx_dat[1] = 8'hA1; tx_dat[2] = 8'hA2; tx_dat[3] = 8'hA3;
        run_txn(8'h80, 8'h0E, 4);

        // R3: read bit set, followed by a byte equal to the good address
        tx_dat[0] = 8'h55;
        run_txn(8'h81, 8'h80, 1);

        // R3: wrong device address
        tx_dat[0] = 8'h66; tx_dat[1] = 8'h77;
        run_txn(8'h90, 8'h08, 2);

        // R7: rejected address, then repeated START with a good transfer
        base = cap_n;
        bus_start;
        send_byte(8'h82, a);
        chk(!a, "R3", "bad address before repeated start", int'(a), 0);
        bus_start;
        send_byte(8'h80, a);
        chk(a, "R7", "address ack after repeated start", int'(a), 1);
        send_byte(8'h05, a);
        send_byte(8'hA5, a);
        bus_stop;
        repeat (4) @(negedge clk);
        chk(cap_n - base == 1, "R7", "writes after repeated start", cap_n - base, 1);
        if (cap_n - base == 1)
            chk(cap_idx[base] == 3'd5 && cap_dat[base] == 8'hA5, "R7",
                "write after repeated start", int'({cap_idx[base], cap_dat[base]}),
                int'({3'd5, 8'hA5}));

        // R7: burst cut by a repeated START, then a new single write
        base = cap_n;
        bus_start;
        send_byte(8'h80, a);
        send_byte(8'h0B, a);
        send_byte(8'hC1, a);
        bus_start;
        send_byte(8'h80, a);
        send_byte(8'h02, a);
        send_byte(8'hC2, a);
        send_byte(8'hC3, a);
        bus_stop;
        repeat (4) @(negedge clk);
        chk(cap_n - base == 2, "R7", "writes across repeated start", cap_n - base, 2);
        if (cap_n - base == 2)
            chk(cap_idx[base+1] == 3'd2 && cap_dat[base+1] == 8'hC2, "R7",
                "second transfer write", int'({cap_idx[base+1], cap_dat[base+1]}),
                int'({3'd2, 8'hC2}));

        // Constrained random transfers
        for (int t = 0; t < 22; t++) begin
            logic [7:0] ab, sb;
            int n;
            ab = ($urandom % 5 == 0) ? 8'($urandom) : 8'h80;
            sb = 8'($urandom);
            n  = $urandom % 6;
            for (int k = 0; k < 8; k++) tx_dat[k] = 8'($urandom);
            run_txn(ab, sb, n);
        end

        chk(strobe_err == 0, "R8", "write strobe width", strobe_err, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule